// File: doc/BRIEF.md
# DMA Channel Interrupt Control Registers

This block holds the interrupt control register and the enable register of a single DMA channel. A byte-wide register bus reaches both. The block watches five completion and error conditions of the channel: local bus error, chain interrupt, transfer timeout, transfer done, and an end-of-transfer status that the block keeps itself. Any of these conditions sets a sticky pending bit. Software clears that bit by writing a one to a strobe position in the control register. The strobe position is not stored.

When the pending bit and the interrupt enable are both set and the programmed level is not zero, the block drives a registered interrupt request and the 3-bit level to an external priority encoder. A level of zero keeps the request off.

The enable register holds the channel's DMA enable bit. Writing a one there also discards the end-of-transfer status, which the attached device raises by asserting its end signal while the end-interrupt enable input is high.

Three small state machines carry the behaviour:
- **Pending machine.** States `PND_IDLE` and `PND_HELD`. Any set condition moves it to `PND_HELD` (`set_evt`). A clear strobe with no set condition in the same cycle returns it to `PND_IDLE` (`clr_stb`).
- **End-status machine.** States `END_IDLE` and `END_SEEN`. A device end with the end-interrupt enable high moves it to `END_SEEN` (`dev_end`). A write of one to the DMA enable returns it to `END_IDLE` (`dma_start`), and this transition takes priority.
- **Request machine.** States `IRQ_OFF` and `IRQ_ON`. It moves to `IRQ_ON` when pending, enable and a non-zero level all hold (`req_ok`). It returns to `IRQ_OFF` when any of the three drops (`req_drop`).

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, the DMA enable and end-status outputs are 0, and the interrupt request is off with level 0.
- R2: The control register is at address 0. On read, bits 7:6 are 0, bit 5 is the pending bit, bit 4 is the interrupt enable, bit 3 reads 0, and bits 2:0 are the level. A write stores bits 4 and 2:0. A write has no effect on bit 5.
- R3: When any one of the five set conditions is high at a clock edge, the pending bit reads 1 after that edge. The five conditions are bus error, chain, timeout, done, and the end status.
- R4: A write to address 0 with bit 3 set clears the pending bit at that edge. A write with bit 3 clear leaves the pending bit unchanged.
- R5: If a set condition and a clear strobe occur in the same cycle, the pending bit stays 1.
- R6: One edge after the pending bit, the enable and a non-zero level are all 1, the request output is 1 and the level output equals the programmed level. Otherwise the request output is 0 and the level output is 0, also one edge later.
- R7: With a programmed level of 0, the request is never raised, even while the pending bit and the enable are both 1.
- R8: The enable register is at address 1. Bit 0 is read/write and drives the DMA enable output. Bits 7:1 read 0.
- R9: The end status is set at an edge where the device end input and the end-interrupt enable input are both 1. A device end while the end-interrupt enable is 0 leaves the end status at 0.
- R10: A write of 1 to bit 0 of the enable register clears the end status at that edge. This takes priority over a device end in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = interrupt control, 1 = DMA enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ev_bus_err | input | 1 | Local bus error condition |
| ev_chain | input | 1 | Chain interrupt condition |
| ev_timeout | input | 1 | Device timeout condition |
| ev_done | input | 1 | Transfer done condition |
| dev_end | input | 1 | Device end-of-transfer signal |
| end_irq_en | input | 1 | Enables dev_end to set the end status |
| end_stat | output | 1 | End-of-transfer status |
| dma_en | output | 1 | DMA enable bit |
| irq_req | output | 1 | Registered interrupt request |
| irq_level | output | 3 | Registered request level, 0 when no request |

## Verification
The assertions assume two things about the inputs. Each bus access lasts one cycle. The condition inputs are synchronous to the clock and settle before each edge. Under those assumptions, the assertions check that a set condition always leaves the pending bit set, that a clear with no set condition always empties it, that a DMA start always clears the end status, and that a request never appears at level zero or without the pending bit and enable behind it. The bench changes every input at the falling edge and keeps each strobe high for exactly one rising edge. It reads results at the next falling edge, after the number of registered stages named in each requirement.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
    localparam int DATA_W = 8;
    localparam int LVL_W  = 3;
    localparam int ADDR_W = 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_ENBL = 1'b1;

    localparam int BIT_PEND = 5;
    localparam int BIT_IEN  = 4;
    localparam int BIT_CLR  = 3;
    localparam int BIT_DEN  = 0;

    localparam int NUM_EVT = 5;

    typedef enum logic { PND_IDLE, PND_HELD } pend_st_t;
    typedef enum logic { END_IDLE, END_SEEN } end_st_t;
    typedef enum logic { IRQ_OFF,  IRQ_ON   } irq_st_t;
endpackage

// File: rtl/dmairq_regs.sv
module dmairq_regs
    import dmairq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              pend,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ien,
    output logic [LVL_W-1:0]  lvl,
    output logic              dma_en,
    output logic              clr_stb,
    output logic              start_stb
);
    logic wr_ctrl;
    logic wr_enbl;
    logic unused_wbits;

    assign wr_ctrl   = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_enbl   = bus_sel && bus_wr && (bus_addr == ADDR_ENBL);
    assign clr_stb   = wr_ctrl && bus_wdata[BIT_CLR];
    assign start_stb = wr_enbl && bus_wdata[BIT_DEN];
    assign unused_wbits = ^{bus_wdata[DATA_W-1:BIT_PEND], bus_wdata[BIT_CLR-1:LVL_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien    <= 1'b0;
            lvl    <= '0;
            dma_en <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ien <= bus_wdata[BIT_IEN];
                lvl <= bus_wdata[LVL_W-1:0];
            end
            if (wr_enbl) begin
                dma_en <= bus_wdata[BIT_DEN];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[BIT_PEND]    = pend;
            bus_rdata[BIT_IEN]     = ien;
            bus_rdata[LVL_W-1:0]   = lvl;
        end else begin
            bus_rdata[BIT_DEN]     = dma_en;
        end
    end

    AST_CLR_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_CTRL) |-> !bus_rdata[BIT_CLR]); // R2
    AST_DEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> dma_en); // R8
endmodule

// File: rtl/dmairq_end_fsm.sv
module dmairq_end_fsm
    import dmairq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dev_end,
    input  logic end_irq_en,
    input  logic start_stb,
    output logic end_stat
);
    end_st_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= END_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            END_IDLE: if (!start_stb && dev_end && end_irq_en) st_d = END_SEEN;
            END_SEEN: if (start_stb) st_d = END_IDLE;
        endcase
    end

    assign end_stat = (st_q == END_SEEN);

    AST_START_CLEARS_END: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !end_stat); // R10
    AST_END_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!end_stat && !end_irq_en) |=> !end_stat); // R9
endmodule

// File: rtl/dmairq_pend_fsm.sv
module dmairq_pend_fsm
    import dmairq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_vec,
    input  logic               clr_stb,
    output logic               pend
);
    pend_st_t st_q, st_d;
    logic     any_set;

    assign any_set = |set_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PND_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PND_IDLE: if (any_set) st_d = PND_HELD;
            PND_HELD: if (clr_stb && !any_set) st_d = PND_IDLE;
        endcase
    end

    assign pend = (st_q == PND_HELD);

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> pend); // R3
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|set_vec) && clr_stb) |=> pend); // R5
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !(|set_vec)) |=> !pend); // R4
endmodule

// File: rtl/dmairq_irq_out.sv
module dmairq_irq_out
    import dmairq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend,
    input  logic             ien,
    input  logic [LVL_W-1:0] lvl,
    output logic             irq_req,
    output logic [LVL_W-1:0] irq_level
);
    irq_st_t          st_q, st_d;
    logic [LVL_W-1:0] lvl_q, lvl_d;
    logic             req_ok;

    assign req_ok = pend && ien && (lvl != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= IRQ_OFF;
            lvl_q <= '0;
        end else begin
            st_q  <= st_d;
            lvl_q <= lvl_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        lvl_d = '0;
        unique case (st_q)
            IRQ_OFF: if (req_ok) begin
                st_d  = IRQ_ON;
                lvl_d = lvl;
            end
            IRQ_ON: if (!req_ok) begin
                st_d  = IRQ_OFF;
            end else begin
                lvl_d = lvl;
            end
        endcase
    end

    assign irq_req   = (st_q == IRQ_ON);
    assign irq_level = lvl_q;

    AST_NO_ZERO_LEVEL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != '0)); // R7
    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(pend && ien)); // R6
    AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_level == '0)); // R6
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
    import dmairq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_bus_err,
    input  logic              ev_chain,
    input  logic              ev_timeout,
    input  logic              ev_done,
    input  logic              dev_end,
    input  logic              end_irq_en,
    output logic              end_stat,
    output logic              dma_en,
    output logic              irq_req,
    output logic [LVL_W-1:0]  irq_level
);
    logic               pend;
    logic               ien;
    logic [LVL_W-1:0]   lvl;
    logic               clr_stb;
    logic               start_stb;
    logic [NUM_EVT-1:0] set_vec;

    assign set_vec = {ev_bus_err, end_stat, ev_chain, ev_timeout, ev_done};

    dmairq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pend      (pend),
        .bus_rdata (bus_rdata),
        .ien       (ien),
        .lvl       (lvl),
        .dma_en    (dma_en),
        .clr_stb   (clr_stb),
        .start_stb (start_stb)
    );

    dmairq_end_fsm u_end (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_end    (dev_end),
        .end_irq_en (end_irq_en),
        .start_stb  (start_stb),
        .end_stat   (end_stat)
    );

    dmairq_pend_fsm u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_stb (clr_stb),
        .pend    (pend)
    );

    dmairq_irq_out u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .ien       (ien),
        .lvl       (lvl),
        .irq_req   (irq_req),
        .irq_level (irq_level)
    );
endmodule

// File: tb/dmairq_ctrl_tb_top.sv
module dmairq_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [0:0] bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ev_bus_err = 0, ev_chain = 0, ev_timeout = 0, ev_done = 0;
    logic       dev_end = 0, end_irq_en = 0;
    logic       end_stat, dma_en, irq_req;
    logic [2:0] irq_level;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmairq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_bus_err(ev_bus_err), .ev_chain(ev_chain), .ev_timeout(ev_timeout),
        .ev_done(ev_done), .dev_end(dev_end), .end_irq_en(end_irq_en),
        .end_stat(end_stat), .dma_en(dma_en), .irq_req(irq_req),
        .irq_level(irq_level)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected below %0d", cyc, WATCHDOG);
            report();
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(logic a, logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0; bus_wdata = 8'h00;
    endtask

    task automatic bus_read(logic a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clear_pending();
        bus_write(1'b0, 8'h08);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        bus_read(1'b0, r); check("R1 ctrl", r, 8'h00);
        bus_read(1'b1, r); check("R1 enbl", r, 8'h00);
        check("R1 outs", {4'b0, dma_en, end_stat, irq_req, 1'b0}, 8'h00);
        check("R1 level", {5'b0, irq_level}, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] r;
        bus_write(1'b0, 8'hFF);
        bus_read(1'b0, r); check("R2 write ff", r, 8'h17);
        bus_write(1'b0, 8'h25);
        bus_read(1'b0, r); check("R2 pend ro", r, 8'h05);
        bus_write(1'b0, 8'h00);
    endtask

    task automatic t_sources();
        logic [7:0] r;
        for (int k = 0; k < 4; k++) begin
            {ev_bus_err, ev_chain, ev_timeout, ev_done} = 4'b1000 >> k;
            step();
            {ev_bus_err, ev_chain, ev_timeout, ev_done} = 4'b0000;
            bus_read(1'b0, r); check($sformatf("R3 source %0d", k), r, 8'h20);
            clear_pending();
            bus_read(1'b0, r); check("R4 clear", r, 8'h00);
        end
    endtask

    task automatic t_clear_zero();
        logic [7:0] r;
        ev_done = 1; step(); ev_done = 0;
        bus_write(1'b0, 8'h00);
        bus_read(1'b0, r); check("R4 strobe 0 keeps", r, 8'h20);
        clear_pending();
    endtask

    task automatic t_set_wins();
        logic [7:0] r;
        ev_timeout = 1;
        bus_write(1'b0, 8'h08);
        ev_timeout = 0;
        bus_read(1'b0, r); check("R5 set wins", r, 8'h20);
        clear_pending();
        bus_read(1'b0, r); check("R5 then clear", r, 8'h00);
    endtask

    task automatic t_request();
        bus_write(1'b0, 8'h15);
        check("R6 idle", {4'b0, irq_req, irq_level}, 8'h00);
        ev_chain = 1; step(); ev_chain = 0;
        check("R6 pipe", {4'b0, irq_req, irq_level}, 8'h00);
        step();
        check("R6 raised", {4'b0, irq_req, irq_level}, 8'h0D);
        bus_write(1'b0, 8'h06);
        step();
        check("R6 enable off", {4'b0, irq_req, irq_level}, 8'h00);
        bus_write(1'b0, 8'h13);
        step();
        check("R6 relevel", {4'b0, irq_req, irq_level}, 8'h0B);
        clear_pending();
        step();
        check("R6 dropped", {4'b0, irq_req, irq_level}, 8'h00);
    endtask

    task automatic t_level_zero();
        logic [7:0] r;
        bus_write(1'b0, 8'h10);
        ev_bus_err = 1; step(); ev_bus_err = 0;
        step(); step();
        bus_read(1'b0, r); check("R7 pend+en", r, 8'h30);
        check("R7 no req", {4'b0, irq_req, irq_level}, 8'h00);
        bus_write(1'b0, 8'h08);
    endtask

    task automatic t_enable_reg();
        logic [7:0] r;
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, r); check("R8 set", r, 8'h01);
        check("R8 pin", {7'b0, dma_en}, 8'h01);
        bus_write(1'b1, 8'hFE);
        bus_read(1'b1, r); check("R8 clr", r, 8'h00);
    endtask

    task automatic t_end_status();
        logic [7:0] r;
        end_irq_en = 0; dev_end = 1; step(); dev_end = 0;
        check("R9 ignored", {7'b0, end_stat}, 8'h00);
        bus_read(1'b0, r); check("R9 no pend", r, 8'h00);
        end_irq_en = 1; dev_end = 1; step(); dev_end = 0;
        check("R9 set", {7'b0, end_stat}, 8'h01);
        step();
        bus_read(1'b0, r); check("R3 end source", r, 8'h20);
        bus_write(1'b1, 8'h01);
        check("R10 start clears", {7'b0, end_stat}, 8'h00);
        clear_pending();
        bus_read(1'b0, r); check("R10 pend clear", r, 8'h00);
        dev_end = 1;
        bus_write(1'b1, 8'h01);
        dev_end = 0;
        check("R10 priority", {7'b0, end_stat}, 8'h00);
        end_irq_en = 0;
        bus_write(1'b1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_sources();
        t_clear_zero();
        t_set_wins();
        t_request();
        t_level_zero();
        t_enable_reg();
        t_end_status();
        done = 1;
        report();
    end
endmodule